// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target with Register Window

This block is a clocked target on a 32-bit bus where the same lines carry an address and then data. A transaction begins when the initiator raises the frame signal. In that first cycle the 4-bit side bus holds a command code. In every later cycle the same 4 bits act as active-low byte enables. The target compares the address with two 64-byte windows, one for memory space and one for I/O space. Both windows map onto one store of sixteen 32-bit registers. If the address falls in a window, the target claims the transaction and serves one or more data phases.

A data phase completes on the clock edge where both the initiator-ready and target-ready signals are high. The initiator marks the last phase by dropping frame. The target adds one wait state before the first read data phase. It raises stop when a burst reaches the last register in the window. A 64-bit address can arrive over two address cycles: the first cycle carries a dual-address code, and the second carries the upper address half and the real command.

All control lines are active high except the byte enables. The read data drive is split into a value and an output enable so that the block can sit behind an I/O pad.

Top module: `mux_bus_target`

## Requirements
- R1: After reset, devsel_o, trdy_o, stop_o and ad_oe_o are all low.
- R2: Command codes on cbe_i in the address cycle are 0110 memory read, 0111 memory write, 0010 I/O read and 0011 I/O write. For a supported command with an address inside its window (memory: MEM_BASE to MEM_BASE+63; I/O: IO_BASE to IO_BASE+63), devsel_o is high in the cycle after the final address cycle.
- R3: An address outside the window, or any other command code, is never claimed: devsel_o stays low and no register changes.
- R4: In a write data phase, byte lane b (ad_i bits 8b+7 to 8b) is stored only when cbe_i[b] is 0. A phase with cbe_i = 1111 stores nothing.
- R5: A read has exactly one cycle with devsel_o high and trdy_o low before the first read data phase. A write raises trdy_o together with devsel_o.
- R6: While irdy_i is low, a data phase does not complete. The register index holds, read data stay stable, and write data are not stored.
- R7: Each completed data phase with frame_i still high moves the transfer to the next 32-bit register, which is address + 4.
- R8: A phase that completes with frame_i low is the last one. In the next cycle devsel_o, trdy_o, stop_o and ad_oe_o are low.
- R9: stop_o is high in the data phase that targets the last register of the window (index 15). If that phase completes with frame_i still high, the target holds devsel_o and stop_o high, with trdy_o low, until frame_i falls.
- R10: cbe_i = 1101 in the first address cycle makes the next cycle a second address cycle. That cycle carries the upper 32 address bits on ad_i and the command on cbe_i. The target claims only a memory command whose upper bits are zero and whose lower address falls in the memory window.
- R11: ad_oe_o is high only in read data phases while trdy_o is high, and ad_o then carries the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | Transaction in progress; low during the last data phase |
| ad_i | input | 32 | Address in the address cycles, write data in data phases |
| ad_o | output | 32 | Read data (zero when not driven) |
| ad_oe_o | output | 1 | Output enable for ad_o |
| cbe_i | input | 4 | Command in address cycles, active-low byte enables in data phases |
| irdy_i | input | 1 | Initiator ready |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Target asks the initiator to end the burst |
| devsel_o | output | 1 | Target has claimed the transaction |

## Verification
The hardest case to reach is the disconnect at the end of the window. A burst must start near the top of the register store, run onto index 15 and still have frame high when that phase completes. Only then does the target enter its hold state with stop high and trdy low.

The stimulus reaches this case in two ways: a four-phase write starting at index 14, and a four-phase read starting at index 14. The bench stops driving phases as soon as it sees stop, then checks the hold cycle. Readback of neighbouring registers shows that the burst did not wrap around to index 0.

A second hard case is the dual-address path. The upper address half must be zero for a claim, and an I/O command after the dual-address code must be refused. Both refusals are shown by reading back the register they would have overwritten.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    localparam int AD_W = 32;
    localparam int BE_W = 4;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_DUAL   = 4'b1101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_RD_WAIT,
        ST_DATA,
        ST_HOLD,
        ST_IGNORE
    } tgt_state_t;

    typedef struct packed {
        logic valid;
        logic write;
        logic io;
    } cmd_info_t;

    function automatic cmd_info_t decode_cmd(input logic [3:0] code);
        cmd_info_t info;
        info = '0;
        unique case (code)
            CMD_IO_RD:  begin info.valid = 1'b1; info.io = 1'b1; end
            CMD_IO_WR:  begin info.valid = 1'b1; info.io = 1'b1; info.write = 1'b1; end
            CMD_MEM_RD: begin info.valid = 1'b1; end
            CMD_MEM_WR: begin info.valid = 1'b1; info.write = 1'b1; end
            default:    info = '0;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
    import mbt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE = 32'h0001_0000,
    parameter logic [31:0] IO_BASE  = 32'h0000_0400,
    parameter int          WORDS    = 16,
    localparam int         IDXW     = $clog2(WORDS),
    localparam int         SH       = IDXW + 2
) (
    input  logic [AD_W-1:0] addr_lo,
    input  logic [AD_W-1:0] addr_hi,
    input  logic            dual,
    input  logic [BE_W-1:0] cmd,
    output logic            hit,
    output logic            is_write,
    output logic [IDXW-1:0] word
);

    cmd_info_t info;
    logic      mem_match;
    logic      io_match;

    always_comb begin
        info      = decode_cmd(cmd);
        mem_match = (addr_lo[AD_W-1:SH] == MEM_BASE[AD_W-1:SH]) &&
                    (!dual || (addr_hi == '0));
        io_match  = !dual && (addr_lo[AD_W-1:SH] == IO_BASE[AD_W-1:SH]);
        hit       = info.valid && (info.io ? io_match : mem_match);
        is_write  = info.write;
        word      = addr_lo[SH-1:2];
    end

endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile
    import mbt_pkg::*;
#(
    parameter int  WORDS = 16,
    localparam int IDXW  = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_word,
    input  logic [BE_W-1:0] be_n,
    input  logic [AD_W-1:0] wdata,
    input  logic [IDXW-1:0] rd_word,
    output logic [AD_W-1:0] rdata
);

    logic [WORDS-1:0][AD_W-1:0] mem_q;
    logic [BE_W-1:0]            lane_we;

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign lane_we[b] = wr_en & ~be_n[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int b = 0; b < BE_W; b++) begin
                if (lane_we[b]) begin
                    mem_q[wr_word][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    assign rdata = mem_q[rd_word];

    assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_q));

    assert_all_lanes_off_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (be_n == '1)) |=> $stable(mem_q));

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
    import mbt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE = 32'h0001_0000,
    parameter logic [31:0] IO_BASE  = 32'h0000_0400,
    parameter int          WORDS    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_i,
    input  logic [31:0] ad_i,
    output logic [31:0] ad_o,
    output logic        ad_oe_o,
    input  logic [3:0]  cbe_i,
    input  logic        irdy_i,
    output logic        trdy_o,
    output logic        stop_o,
    output logic        devsel_o
);

    localparam int              IDXW = $clog2(WORDS);
    localparam logic [IDXW-1:0] LAST = IDXW'(WORDS - 1);

    tgt_state_t      state_q;
    logic [31:0]     lo_q;
    logic [IDXW-1:0] word_q;
    logic            wr_q;

    logic [31:0]     dec_lo;
    logic [31:0]     dec_hi;
    logic            dec_dual;
    logic            dec_hit;
    logic            dec_wr;
    logic [IDXW-1:0] dec_word;
    logic [31:0]     rd_data;
    logic            phase_done;
    logic            at_last;

    always_comb begin
        dec_dual = (state_q == ST_ADDR_HI);
        dec_lo   = dec_dual ? lo_q : ad_i;
        dec_hi   = dec_dual ? ad_i : '0;
    end

    mbt_decode #(
        .MEM_BASE (MEM_BASE),
        .IO_BASE  (IO_BASE),
        .WORDS    (WORDS)
    ) u_decode (
        .addr_lo  (dec_lo),
        .addr_hi  (dec_hi),
        .dual     (dec_dual),
        .cmd      (cbe_i),
        .hit      (dec_hit),
        .is_write (dec_wr),
        .word     (dec_word)
    );

    assign phase_done = (state_q == ST_DATA) && irdy_i;
    assign at_last    = (word_q == LAST);

    mbt_regfile #(
        .WORDS   (WORDS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (phase_done && wr_q),
        .wr_word (word_q),
        .be_n    (cbe_i),
        .wdata   (ad_i),
        .rd_word (word_q),
        .rdata   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lo_q    <= '0;
            word_q  <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frame_i) begin
                        if (cbe_i == CMD_DUAL) begin
                            lo_q    <= ad_i;
                            state_q <= ST_ADDR_HI;
                        end else if (dec_hit) begin
                            word_q  <= dec_word;
                            wr_q    <= dec_wr;
                            state_q <= dec_wr ? ST_DATA : ST_RD_WAIT;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_HI: begin
                    if (dec_hit) begin
                        word_q  <= dec_word;
                        wr_q    <= dec_wr;
                        state_q <= dec_wr ? ST_DATA : ST_RD_WAIT;
                    end else begin
                        state_q <= ST_IGNORE;
                    end
                end
                ST_RD_WAIT: state_q <= ST_DATA;
                ST_DATA: begin
                    if (irdy_i) begin
                        if (!frame_i)     state_q <= ST_IDLE;
                        else if (at_last) state_q <= ST_HOLD;
                        else              word_q  <= word_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!frame_i) state_q <= ST_IDLE;
                end
                ST_IGNORE: begin
                    if (!frame_i && !irdy_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        devsel_o = (state_q == ST_RD_WAIT) || (state_q == ST_DATA) || (state_q == ST_HOLD);
        trdy_o   = (state_q == ST_DATA);
        stop_o   = ((state_q == ST_DATA) && at_last) || (state_q == ST_HOLD);
        ad_oe_o  = (state_q == ST_DATA) && !wr_q;
        ad_o     = ad_oe_o ? rd_data : '0;
    end

    assert_claim_after_frame_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(devsel_o) |-> $past(frame_i));

    assert_read_wait_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(devsel_o) && !wr_q) |-> !trdy_o);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (trdy_o && !irdy_i) |=> (trdy_o && $stable(word_q) && $stable(ad_o)));

    assert_burst_step_R7: assert property (@(posedge clk) disable iff (rst)
        (trdy_o && irdy_i && frame_i && !stop_o) |=> (word_q == $past(word_q) + 1'b1));

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (trdy_o && irdy_i && !frame_i) |=> (!devsel_o && !trdy_o && !stop_o && !ad_oe_o));

    assert_disconnect_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (trdy_o && stop_o && irdy_i && frame_i) |=> (devsel_o && stop_o && !trdy_o));

    assert_drive_window_R11: assert property (@(posedge clk) disable iff (rst)
        ad_oe_o |-> (trdy_o && devsel_o));

endmodule

// File: tb/tb_mux_bus_target.sv
module tb_mux_bus_target;

    localparam logic [31:0] MEMB = 32'h0001_0000;
    localparam logic [31:0] IOB  = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        irdy = 1'b0;
    logic [31:0] ad_o;
    logic        ad_oe, trdy, stop, devsel;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [31:0] shadow [16];
    logic [31:0] sb_q [$];
    logic [31:0] wd_arr [8];
    logic [3:0]  be_arr [8];

    always #2 clk = ~clk;

    mux_bus_target dut (
        .clk      (clk),
        .rst      (rst),
        .frame_i  (frame),
        .ad_i     (ad),
        .ad_o     (ad_o),
        .ad_oe_o  (ad_oe),
        .cbe_i    (cbe),
        .irdy_i   (irdy),
        .trdy_o   (trdy),
        .stop_o   (stop),
        .devsel_o (devsel)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] ben);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (!ben[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // scoreboard monitor: every completing read phase pops one expected word
    always @(negedge clk) begin
        if (!rst && trdy && irdy && ad_oe) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R11 unexpected read data", ad_o, 32'h0);
            end else begin
                logic [31:0] e;
                e = sb_q.pop_front();
                chk(ad_o == e, "R11 read data", ad_o, e);
            end
        end
    end

    task automatic txn(input bit dual, input logic [31:0] hi, input logic [31:0] addr,
                       input logic [3:0] cmd, input int n, input bit claim,
                       input int stall_at, input int wbase, input bit wr);
        bit stopped = 0;
        @(posedge clk); #1;
        frame = 1; irdy = 0; ad = addr; cbe = dual ? 4'b1101 : cmd;
        if (dual) begin
            @(posedge clk); #1;
            ad = hi; cbe = cmd;
        end
        if (!claim) begin
            @(posedge clk); #1;
            frame = 1; irdy = 1; ad = 32'hFFFF_FFFF; cbe = 4'h0;
            repeat (3) begin
                @(negedge clk);
                chk(!devsel, "R3 no claim", {31'd0, devsel}, 32'd0);
            end
            @(posedge clk); #1;
            frame = 0; irdy = 0;
            @(negedge clk);
            chk(!devsel, "R3 no claim after", {31'd0, devsel}, 32'd0);
            return;
        end
        for (int i = 0; i < n; i++) begin
            int  w;
            bit  got;
            w = wbase + i;
            @(posedge clk); #1;
            if (i == stall_at) begin
                frame = 1; irdy = 0; ad = 32'hDEAD_BEEF; cbe = 4'h0;
                repeat (2) begin
                    @(negedge clk);
                    chk(trdy, "R6 trdy held in stall", {31'd0, trdy}, 32'd1);
                    if (!wr) chk(ad_o == shadow[w], "R6 stable read data", ad_o, shadow[w]);
                    @(posedge clk); #1;
                end
            end
            frame = (i < n - 1); irdy = 1; cbe = be_arr[i];
            ad = wr ? wd_arr[i] : 32'h0;
            if (!wr) sb_q.push_back(shadow[w]);
            got = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (i == 0 && k == 0) begin
                    chk(devsel, "R2 claim", {31'd0, devsel}, 32'd1);
                    chk(trdy == wr, "R5 first phase ready", {31'd0, trdy}, {31'd0, wr});
                end
                if (trdy) begin got = 1; break; end
                @(posedge clk); #1;
            end
            chk(got, "R7 phase completes", {31'd0, got}, 32'd1);
            chk(stop == (w == 15), "R9 stop at window end", {31'd0, stop}, {31'd0, w == 15});
            if (wr) shadow[w] = merge(shadow[w], wd_arr[i], be_arr[i]);
            if (stop && i < n - 1) begin stopped = 1; break; end
        end
        @(posedge clk); #1;
        if (stopped) begin
            frame = 0; irdy = 0;
            @(negedge clk);
            chk(devsel && stop && !trdy, "R9 hold after disconnect",
                {29'd0, devsel, stop, trdy}, 32'b110);
            @(posedge clk); #1;
            @(negedge clk);
            chk(!devsel && !stop, "R9 release after frame falls", {30'd0, devsel, stop}, 32'd0);
        end else begin
            frame = 0; irdy = 0;
            @(negedge clk);
            chk(!devsel && !trdy && !stop && !ad_oe, "R8 release after last phase",
                {28'd0, devsel, trdy, stop, ad_oe}, 32'd0);
        end
    endtask

    task automatic fill(input logic [31:0] seed, input logic [3:0] ben);
        for (int i = 0; i < 8; i++) begin
            wd_arr[i] = seed + 32'h0101_0101 * i;
            be_arr[i] = ben;
        end
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(!devsel && !trdy && !stop && !ad_oe, "R1 reset outputs",
            {28'd0, devsel, trdy, stop, ad_oe}, 32'd0);

        // R7 R2: memory write burst to registers 0..3, then read back with a stall (R6)
        fill(32'hA0A1_A2A3, 4'h0);
        txn(0, 0, MEMB, 4'b0111, 4, 1, -1, 0, 1);
        fill(0, 4'h0);
        txn(0, 0, MEMB, 4'b0110, 4, 1, 2, 0, 0);

        // R4: partial lanes at register 5, no lanes at register 6, write stall (R6)
        fill(32'h1122_3344, 4'b0101);
        txn(0, 0, MEMB + 20, 4'b0111, 1, 1, -1, 5, 1);
        fill(32'h5566_7788, 4'b1111);
        txn(0, 0, MEMB + 24, 4'b0111, 1, 1, -1, 6, 1);
        fill(32'h0BAD_0BAD, 4'h0);
        wd_arr[1] = 32'hC0DE_0001;
        txn(0, 0, MEMB + 28, 4'b0111, 2, 1, 1, 7, 1);
        fill(0, 4'h0);
        txn(0, 0, MEMB + 20, 4'b0110, 4, 1, -1, 5, 0);

        // R2: I/O window maps to the same store
        fill(32'h00C0_FFEE, 4'h0);
        txn(0, 0, IOB + 8, 4'b0011, 1, 1, -1, 2, 1);
        fill(0, 4'h0);
        txn(0, 0, IOB + 8, 4'b0010, 1, 1, -1, 2, 0);

        // R3: misses
        txn(0, 0, MEMB + 64, 4'b0111, 1, 0, -1, 0, 1);
        txn(0, 0, MEMB, 4'b1010, 1, 0, -1, 0, 1);
        txn(0, 0, MEMB, 4'b0011, 1, 0, -1, 0, 1);
        txn(0, 0, IOB - 4, 4'b0110, 1, 0, -1, 0, 0);
        txn(0, 0, MEMB, 4'b0110, 3, 1, -1, 0, 0);

        // R9: write burst runs into the window end
        fill(32'h7E7E_0000, 4'h0);
        txn(0, 0, MEMB + 56, 4'b0111, 4, 1, -1, 14, 1);
        fill(0, 4'h0);
        txn(0, 0, MEMB, 4'b0110, 1, 1, -1, 0, 0);
        txn(0, 0, MEMB + 52, 4'b0110, 3, 1, -1, 13, 0);
        txn(0, 0, MEMB + 56, 4'b0110, 4, 1, -1, 14, 0);

        // R10: dual address cycles
        fill(32'h9999_0009, 4'h0);
        txn(1, 32'h0, MEMB + 36, 4'b0111, 1, 1, -1, 9, 1);
        fill(0, 4'h0);
        txn(1, 32'h0, MEMB + 36, 4'b0110, 1, 1, -1, 9, 0);
        txn(1, 32'h1, MEMB + 36, 4'b0111, 1, 0, -1, 9, 1);
        txn(1, 32'h0, IOB + 36, 4'b0011, 1, 0, -1, 9, 1);
        txn(0, 0, MEMB + 36, 4'b0110, 1, 1, -1, 9, 0);

        repeat (2) @(posedge clk);
        chk(sb_q.size() == 0, "R11 all reads observed", sb_q.size(), 32'd0);
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule